// File: doc/BRIEF.md
# ARP request wake detector

This block watches a received Ethernet frame one byte at a time and decides whether the frame is an ARP request addressed to this station. It tracks each byte's position from the start of the frame and tests a fixed set of fields at fixed positions. Those positions move four bytes later when the frame carries a single 802.1Q tag. When the last byte of the frame arrives, the block gives its decision as a single-cycle pulse on `arp_event`, which a power-management controller can use as a wake request. The block takes no error indication, so a frame with a bad checksum or a framing error is judged on its bytes alone.

The receive path presents bytes with `rx_valid`. `rx_sof` marks the first byte of a frame and `rx_eof` marks the last. Cycles with `rx_valid` low are gaps and are skipped. Three configuration inputs qualify the decision: `cfg_arp_en` turns the feature on, `cfg_bcast_ok` reflects whether broadcast reception is allowed, and `cfg_target` holds the low 16 bits of the station's IPv4 address. These inputs are read in the decision cycle.

The control is a four-state machine.
- `ST_IDLE` waits for a start byte.
- `ST_HEADER` covers the Ethernet header up to the type field, including the tag when one is present.
- `ST_BODY` covers the rest of the frame.
- `ST_DECIDE` is the single cycle after the end byte, in which `arp_event` is driven.

The transitions are:
- `IDLE→HEADER`: on a start byte.
- `HEADER→BODY`: on the byte that completes the type field.
- `HEADER→HEADER` and `BODY→HEADER`: on a start byte in mid-frame, which restarts parsing.
- `HEADER→DECIDE` and `BODY→DECIDE`: on an end byte.
- `DECIDE→HEADER`: on a start byte arriving back to back.
- `DECIDE→IDLE`: otherwise.
- `IDLE→DECIDE` and `DECIDE→DECIDE`: on a one-byte frame.

Top module: `arp_wake_detect`

## Requirements
- R1: `arp_event` is high for exactly one cycle: the cycle after the clock edge that accepts the end byte (`rx_valid` and `rx_eof` high). It is high only when every condition in R2 to R6 holds. Otherwise it stays low, including out of reset.
- R2: No event unless `cfg_arp_en` and `cfg_bcast_ok` are both 1.
- R3: Bytes 1 to 6 of the frame must all be 0xFF. Byte 1 is the byte accepted with `rx_sof`.
- R4: Bytes 13 and 14 must read 0x0806. Two-byte fields are big-endian: the lower-numbered byte is the high byte.
- R5: Bytes 21 and 22 must read 0x0001.
- R6: Bytes 41 and 42 must equal `cfg_target`, with byte 41 as bits 15:8.
- R7: A `cfg_target` of 0x0000 never produces an event, even when bytes 41 and 42 are both zero.
- R8: When bytes 13 and 14 read 0x8100, the type is taken from bytes 17 and 18. The operation moves to bytes 25 and 26 and the address to bytes 45 and 46.
- R9: A frame that ends before the last address byte (byte 42, or 46 when tagged) gives no event. A frame that ends exactly on that byte does give an event.
- R10: Cycles with `rx_valid` low inside a frame do not affect the result. A start byte in mid-frame discards the frame in progress and starts a new one.
- R11: A start byte accepted in the decision cycle of the previous frame begins a new frame. Both frames receive their own decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| cfg_arp_en | input | 1 | ARP wake detection enabled |
| cfg_bcast_ok | input | 1 | Broadcast reception allowed |
| cfg_target | input | 16 | Low half of the station IPv4 address; zero disables detection |
| arp_event | output | 1 | One-cycle pulse for a matching ARP request |

## Verification
A valid request is sent first, untagged and then tagged, so that the base case and the shifted field positions are both known to fire.

Each single-field corruption then flips the result on its own, which shows that every condition is tested:
- destination byte;
- type;
- operation;
- address;
- each enable;
- the zero target.

Truncated frames ending one byte before the address completes, and exactly on it, pin down the length boundary.

Idle gaps, a restart in mid-frame and back-to-back frames show that position counting follows accepted bytes rather than clock cycles.

// File: rtl/arp_wake_pkg.sv
package arp_wake_pkg;
    localparam int BYTE_W    = 8;
    localparam int DST_LAST  = 6;
    localparam int TYPE_LO   = 14;
    localparam int OPER_LO   = 22;
    localparam int TPA_LO    = 42;
    localparam int TAG_SHIFT = 4;

    localparam logic [15:0] ETYPE_ARP = 16'h0806;
    localparam logic [15:0] ETYPE_TAG = 16'h8100;
    localparam logic [15:0] OPER_REQ  = 16'h0001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEADER,
        ST_BODY,
        ST_DECIDE
    } wake_state_t;
endpackage

// File: rtl/arp_byte_pos.sv
module arp_byte_pos #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             sof,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] seen_q;

    // 1-based position of the byte currently on the bus; saturates
    always_comb begin
        if (sof)
            pos = CNT_ONE;
        else if (seen_q == CNT_MAX)
            pos = CNT_MAX;
        else
            pos = seen_q + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_q <= '0;
        else if (valid)
            seen_q <= pos;
    end
endmodule

// File: rtl/arp_field_match.sv
module arp_field_match
    import arp_wake_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              sof,
    input  logic [CNT_W-1:0]  pos,
    input  logic [BYTE_W-1:0] data,
    output logic              dst_ok,
    output logic              type_ok,
    output logic              oper_ok,
    output logic              tpa_seen,
    output logic [15:0]       tpa_val,
    output logic              hdr_done
);
    localparam logic [CNT_W-1:0] P_DST_LAST = CNT_W'(DST_LAST);
    localparam logic [CNT_W-1:0] P_TYPE_LO  = CNT_W'(TYPE_LO);
    localparam logic [CNT_W-1:0] P_TAGTYPE  = CNT_W'(TYPE_LO + TAG_SHIFT);
    localparam logic [CNT_W-1:0] P_OPER_LO  = CNT_W'(OPER_LO);
    localparam logic [CNT_W-1:0] P_TPA_LO   = CNT_W'(TPA_LO);
    localparam logic [CNT_W-1:0] P_SHIFT    = CNT_W'(TAG_SHIFT);

    logic [BYTE_W-1:0] prev_q;
    logic              tagged_q;
    logic [15:0]       pair;
    logic [CNT_W-1:0]  shift;

    assign pair  = {prev_q, data};
    assign shift = tagged_q ? P_SHIFT : '0;

    // byte that completes the Ethernet type field
    assign hdr_done = valid && !sof &&
                      (((pos == P_TYPE_LO) && (pair != ETYPE_TAG)) ||
                       (tagged_q && (pos == P_TAGTYPE)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            tagged_q <= 1'b0;
            dst_ok   <= 1'b0;
            type_ok  <= 1'b0;
            oper_ok  <= 1'b0;
            tpa_seen <= 1'b0;
            tpa_val  <= '0;
        end else if (valid) begin
            prev_q <= data;
            if (sof) begin
                dst_ok   <= (data == 8'hFF);
                tagged_q <= 1'b0;
                type_ok  <= 1'b0;
                oper_ok  <= 1'b0;
                tpa_seen <= 1'b0;
                tpa_val  <= '0;
            end else begin
                if (pos <= P_DST_LAST)
                    dst_ok <= dst_ok && (data == 8'hFF);
                if (pos == P_TYPE_LO) begin
                    if (pair == ETYPE_TAG)
                        tagged_q <= 1'b1;
                    else
                        type_ok <= (pair == ETYPE_ARP);
                end
                if (tagged_q && (pos == P_TAGTYPE))
                    type_ok <= (pair == ETYPE_ARP);
                if (pos == P_OPER_LO + shift)
                    oper_ok <= (pair == OPER_REQ);
                if (pos == P_TPA_LO + shift) begin
                    tpa_val  <= pair;
                    tpa_seen <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/arp_wake_fsm.sv
module arp_wake_fsm
    import arp_wake_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic        sof,
    input  logic        eof,
    input  logic        hdr_done,
    input  logic        dst_ok,
    input  logic        type_ok,
    input  logic        oper_ok,
    input  logic        tpa_seen,
    input  logic [15:0] tpa_val,
    input  logic        cfg_arp_en,
    input  logic        cfg_bcast_ok,
    input  logic [15:0] cfg_target,
    output logic        arp_event
);
    wake_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DECIDE: begin
                if (valid && sof)
                    state_d = eof ? ST_DECIDE : ST_HEADER;
                else
                    state_d = ST_IDLE;
            end
            ST_HEADER: begin
                if (valid && eof)
                    state_d = ST_DECIDE;
                else if (valid && sof)
                    state_d = ST_HEADER;
                else if (hdr_done)
                    state_d = ST_BODY;
            end
            ST_BODY: begin
                if (valid && eof)
                    state_d = ST_DECIDE;
                else if (valid && sof)
                    state_d = ST_HEADER;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        arp_event = 1'b0;
        if (state_q == ST_DECIDE)
            arp_event = cfg_arp_en && cfg_bcast_ok && (cfg_target != '0) &&
                        dst_ok && type_ok && oper_ok && tpa_seen &&
                        (tpa_val == cfg_target);
    end
endmodule

// File: rtl/arp_wake_detect.sv
module arp_wake_detect
    import arp_wake_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              cfg_arp_en,
    input  logic              cfg_bcast_ok,
    input  logic [15:0]       cfg_target,
    output logic              arp_event
);
    logic [CNT_W-1:0] pos;
    logic             dst_ok, type_ok, oper_ok, tpa_seen, hdr_done;
    logic [15:0]      tpa_val;

    arp_byte_pos #(.CNT_W(CNT_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (rx_valid),
        .sof   (rx_sof),
        .pos   (pos)
    );

    arp_field_match #(.CNT_W(CNT_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (rx_valid),
        .sof      (rx_sof),
        .pos      (pos),
        .data     (rx_data),
        .dst_ok   (dst_ok),
        .type_ok  (type_ok),
        .oper_ok  (oper_ok),
        .tpa_seen (tpa_seen),
        .tpa_val  (tpa_val),
        .hdr_done (hdr_done)
    );

    arp_wake_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid        (rx_valid),
        .sof          (rx_sof),
        .eof          (rx_eof),
        .hdr_done     (hdr_done),
        .dst_ok       (dst_ok),
        .type_ok      (type_ok),
        .oper_ok      (oper_ok),
        .tpa_seen     (tpa_seen),
        .tpa_val      (tpa_val),
        .cfg_arp_en   (cfg_arp_en),
        .cfg_bcast_ok (cfg_bcast_ok),
        .cfg_target   (cfg_target),
        .arp_event    (arp_event)
    );
endmodule

// File: rtl/arp_wake_detect_chk.sv
module arp_wake_detect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        rx_eof,
    input logic        cfg_arp_en,
    input logic        cfg_bcast_ok,
    input logic [15:0] cfg_target,
    input logic        arp_event
);
    // R1
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arp_event |=> !arp_event);

    // R1
    event_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arp_event |-> $past(rx_valid && rx_eof));

    // R2
    event_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arp_event |-> (cfg_arp_en && cfg_bcast_ok));

    // R7
    zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_target == 16'h0000) |-> !arp_event);
endmodule

bind arp_wake_detect arp_wake_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_eof       (rx_eof),
    .cfg_arp_en   (cfg_arp_en),
    .cfg_bcast_ok (cfg_bcast_ok),
    .cfg_target   (cfg_target),
    .arp_event    (arp_event)
);

// File: tb/arp_wake_detect_tb.sv
module arp_wake_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        cfg_arp_en = 1'b1;
    logic        cfg_bcast_ok = 1'b1;
    logic [15:0] cfg_target = 16'h0A05;
    logic        arp_event;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit    exp;
        string req;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] fb[$];
    logic       pend = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    arp_wake_detect u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .cfg_arp_en   (cfg_arp_en),
        .cfg_bcast_ok (cfg_bcast_ok),
        .cfg_target   (cfg_target),
        .arp_event    (arp_event)
    );

    // build a frame into fb; trunc > 0 cuts it to that many bytes
    task automatic build(bit tag, bit bad_dst, logic [15:0] etype,
                         logic [15:0] oper, logic [15:0] tpa, int trunc);
        fb.delete();
        for (int i = 0; i < 6; i++) fb.push_back((bad_dst && i == 2) ? 8'hFE : 8'hFF);
        for (int i = 0; i < 6; i++) fb.push_back(8'(8'h20 + i));
        if (tag) begin
            fb.push_back(8'h81); fb.push_back(8'h00);
            fb.push_back(8'h00); fb.push_back(8'h05);
        end
        fb.push_back(etype[15:8]); fb.push_back(etype[7:0]);
        fb.push_back(8'h00); fb.push_back(8'h01); fb.push_back(8'h08);
        fb.push_back(8'h00); fb.push_back(8'h06); fb.push_back(8'h04);
        fb.push_back(oper[15:8]); fb.push_back(oper[7:0]);
        for (int i = 0; i < 6; i++) fb.push_back(8'(8'h40 + i));
        fb.push_back(8'hC0); fb.push_back(8'hA8); fb.push_back(8'h0A); fb.push_back(8'h01);
        for (int i = 0; i < 6; i++) fb.push_back(8'h00);
        fb.push_back(8'hC0); fb.push_back(8'hA8); fb.push_back(tpa[15:8]); fb.push_back(tpa[7:0]);
        while (fb.size() < 60) fb.push_back(8'h00);
        if (trunc > 0)
            while (fb.size() > trunc) void'(fb.pop_back());
    endtask

    // driver: queues the expected decision, then drives the bytes
    task automatic send(bit gaps, bit with_eof, bit exp, string req);
        if (with_eof) exp_q.push_back('{exp, req});
        for (int i = 0; i < fb.size(); i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'hFF;
            end
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = fb[i];
            rx_sof   = (i == 0);
            rx_eof   = with_eof && (i == fb.size() - 1);
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: one decision is due in the cycle after each accepted end byte
    always @(posedge clk) pend <= rst_n && rx_valid && rx_eof;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R1: unexpected decision, arp_event=%0b expected none", arp_event);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (arp_event !== e.exp) begin
                        fails++;
                        $display("FAIL %s: arp_event=%0b expected %0b", e.req, arp_event, e.exp);
                    end
                end
            end else if (arp_event !== 1'b0) begin
                checks++; fails++;
                $display("FAIL R1: arp_event=%0b outside decision cycle, expected 0", arp_event);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R1 reset state
        if (arp_event !== 1'b0) begin
            fails++;
            $display("FAIL R1: arp_event=%0b after reset expected 0", arp_event);
        end

        // R1 R3 R4 R5 R6 basic match
        build(0, 0, 16'h0806, 16'h0001, 16'h0A05, 0); send(0, 1, 1, "R1"); idle(2);
        // R6 address mismatch
        build(0, 0, 16'h0806, 16'h0001, 16'h0A06, 0); send(0, 1, 0, "R6"); idle(2);
        // R3 one destination byte not broadcast
        build(0, 1, 16'h0806, 16'h0001, 16'h0A05, 0); send(0, 1, 0, "R3"); idle(2);
        // R4 IPv4 type
        build(0, 0, 16'h0800, 16'h0001, 16'h0A05, 0); send(0, 1, 0, "R4"); idle(2);
        // R5 reply operation
        build(0, 0, 16'h0806, 16'h0002, 16'h0A05, 0); send(0, 1, 0, "R5"); idle(2);
        // R2 enable off
        cfg_arp_en = 1'b0;
        build(0, 0, 16'h0806, 16'h0001, 16'h0A05, 0); send(0, 1, 0, "R2"); idle(2);
        cfg_arp_en = 1'b1; cfg_bcast_ok = 1'b0;
        send(0, 1, 0, "R2"); idle(2);
        cfg_bcast_ok = 1'b1;
        // R7 zero target with matching zero address
        cfg_target = 16'h0000;
        build(0, 0, 16'h0806, 16'h0001, 16'h0000, 0); send(0, 1, 0, "R7"); idle(2);
        cfg_target = 16'h0A05;
        // R8 tagged frame
        build(1, 0, 16'h0806, 16'h0001, 16'h0A05, 0); send(0, 1, 1, "R8"); idle(2);
        build(1, 0, 16'h0806, 16'h0002, 16'h0A05, 0); send(0, 1, 0, "R8"); idle(2);
        // R9 length boundary
        build(0, 0, 16'h0806, 16'h0001, 16'h0A05, 41); send(0, 1, 0, "R9"); idle(2);
        build(0, 0, 16'h0806, 16'h0001, 16'h0A05, 42); send(0, 1, 1, "R9"); idle(2);
        build(1, 0, 16'h0806, 16'h0001, 16'h0A05, 45); send(0, 1, 0, "R9"); idle(2);
        // R10 gaps and mid-frame restart
        build(1, 0, 16'h0806, 16'h0001, 16'h0A05, 0); send(1, 1, 1, "R10"); idle(2);
        build(0, 0, 16'h0806, 16'h0001, 16'h0A05, 20); send(0, 0, 0, "R10");
        build(0, 0, 16'h0806, 16'h0001, 16'h0A05, 0); send(0, 1, 1, "R10"); idle(2);
        // R11 back-to-back frames
        build(0, 0, 16'h0806, 16'h0001, 16'h0A05, 0); send(0, 1, 1, "R11");
        build(0, 0, 16'h0806, 16'h0001, 16'h0A06, 0); send(0, 1, 0, "R11");
        build(0, 0, 16'h0806, 16'h0001, 16'h0A05, 0); send(0, 1, 1, "R11"); idle(4);

        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d decisions missing expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule